// File: doc/BRIEF.md
# Iterative CORDIC Euler Vector Rotator

This block turns a three-component fixed-point vector into its North-East-Down form by applying three Euler angle rotations in turn. One CORDIC kernel, working in rotation mode, does all three plane rotations one after another. The block uses no sine or cosine table and no general multipliers in the rotation path. Only two constant multipliers remain, and they remove the CORDIC gain after each plane. The design targets area, not throughput: it takes one vector at a time and runs for a fixed number of cycles per vector.

A producer offers a vector and an angle triple by raising `inValid`. The block accepts the pair when `ready` is high and then lowers `ready` until the result has been delivered. The result appears on `uOut` together with a single-cycle `outValid` pulse, and stays there until the next result. A synchronous `restart` input drops any computation in progress at once and returns the block to its idle state.

Each angle is first brought into [-pi/2, pi/2] by a half-turn that negates both components of its plane. The CORDIC iterations then converge for any input angle between -pi and pi.

Top module: `eulerNedRotator`

## Requirements
- R1: After reset `ready` is 1, `outValid` is 0 and `uOut` is all zeros.
- R2: An input is accepted on a rising edge where `ready` and `inValid` are both 1 and `restart` is 0. `ready` is 0 from the next cycle onward. It returns to 1 in the cycle after the `outValid` pulse.
- R3: Inputs do not start a computation while `inValid` is 0. Inputs offered while `ready` is 0 are also ignored: they never produce an `outValid` and do not change the result in progress.
- R4: `outValid` is high for exactly one cycle. It rises 3*(N+2) rising edges after the accepting edge, where N is the data word length (54 edges for N=16).
- R5: Encodings: data are signed two's complement, DW bits each, with element k at bits [k*DW +: DW] (0 = north, 1 = east, 2 = down). Angles are signed with AW-3 fraction bits (radians times 2^(AW-3)), with element 0 = phi, 1 = theta, 2 = psi. The plane rotation rule is a' = a*cos - b*sin, b' = a*sin + b*cos. It is applied first with psi to the pair (north, east), then with theta to the pair (down, north), then with phi to the pair (east, down). The output matches this within 6 LSB when the input vector norm stays below 2^(DW-2).
- R6: Angles in (pi/2, pi] and [-pi, -pi/2) give the same accuracy as R5. After folding, the CORDIC residual angle lies within [-pi/2, pi/2].
- R7: The overall gain is unity. With all angles zero, `uOut` equals `uIn` within 6 LSB.
- R8: When `restart` is 1 on a rising edge, the current computation is dropped and `uOut` is cleared. `ready` is 1 and `outValid` is 0 in the following cycle, and the dropped input never yields an `outValid`. `restart` takes priority over a simultaneous `inValid`.
- R9: `uOut` holds its last result unchanged until the next `outValid` pulse or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous abort and clear of the computation |
| inValid | input | 1 | Input vector and angles are valid this cycle |
| uIn | input | 3*DW | Input vector, element k at bits [k*DW +: DW] |
| angIn | input | 3*AW | Angles phi, theta, psi, element k at bits [k*AW +: AW] |
| ready | output | 1 | Block will accept an input this cycle |
| outValid | output | 1 | One-cycle strobe marking a new result on uOut |
| uOut | output | 3*DW | Rotated vector, same layout and scaling as uIn |

## Verification
A wrong stage counter or wrong pair selection shows up in the first result, 54 edges after acceptance. The output then has the right magnitude but rotates the wrong components, or rotates by the wrong angle. A faulty iteration counter moves the `outValid` edge away from the expected cycle, and a broken fold or gain constant shows as large errors on single-angle cases near pi. Control faults around `ready` and `restart` show within one or two cycles: an extra pulse, a missing pulse, or a `ready` that comes back early.

// File: rtl/eulerRotPkg.sv
package eulerRotPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FOLD,
    ST_ROT,
    ST_COMP,
    ST_DONE
  } rotState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       clear;
    logic       load;
    logic       fold;
    logic       iter;
    logic       comp;
    logic       finish;
    logic [1:0] stage;
    logic [5:0] iterIdx;
  } rotCtl_t;

  // first component of the plane rotated in a given stage
  function automatic logic [1:0] pairFirst(input logic [1:0] stage);
    case (stage)
      2'd0:    return 2'd0;
      2'd1:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // second component of the plane rotated in a given stage
  function automatic logic [1:0] pairSecond(input logic [1:0] stage);
    case (stage)
      2'd0:    return 2'd1;
      2'd1:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  // angle used in a given stage: psi, then theta, then phi
  function automatic logic [1:0] angleOf(input logic [1:0] stage);
    case (stage)
      2'd0:    return 2'd2;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/eulerRotCtl.sv
module eulerRotCtl
  import eulerRotPkg::*;
#(
  parameter int ITER = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    restart,
  input  logic    inValid,
  output logic    ready,
  output logic    outValid,
  output rotCtl_t ctl
);

  localparam int IXW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int LAT = 3 * (ITER + 2);
  localparam int LCW = $clog2(LAT + 1) + 1;

  rotState_t      state;
  logic [1:0]     stage;
  logic [IXW-1:0] iterCnt;
  logic [LCW-1:0] latCnt;
  logic           accept;

  assign ready    = (state == ST_IDLE);
  assign outValid = (state == ST_DONE);
  assign accept   = ready && inValid && !restart;

  always_comb begin
    ctl         = '0;
    ctl.clear   = restart;
    ctl.load    = accept;
    ctl.fold    = (state == ST_FOLD) && !restart;
    ctl.iter    = (state == ST_ROT) && !restart;
    ctl.comp    = (state == ST_COMP) && !restart;
    ctl.finish  = (state == ST_COMP) && (stage == 2'd2) && !restart;
    ctl.stage   = stage;
    ctl.iterIdx = 6'(iterCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      state   <= ST_IDLE;
      stage   <= '0;
      iterCnt <= '0;
      latCnt  <= '0;
    end else begin
      if (state != ST_IDLE) latCnt <= latCnt + 1'b1;
      case (state)
        ST_IDLE: if (inValid) begin
          state  <= ST_FOLD;
          stage  <= '0;
          latCnt <= '0;
        end
        ST_FOLD: begin
          state   <= ST_ROT;
          iterCnt <= '0;
        end
        ST_ROT: begin
          if (iterCnt == IXW'(ITER - 1)) state <= ST_COMP;
          else iterCnt <= iterCnt + 1'b1;
        end
        ST_COMP: begin
          if (stage == 2'd2) state <= ST_DONE;
          else begin
            stage <= stage + 1'b1;
            state <= ST_FOLD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !ready); // R2
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !inValid) |=> ready); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (latCnt == LCW'(LAT))); // R4
  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (ready && !outValid)); // R8

endmodule

// File: rtl/eulerRotDatapath.sv
module eulerRotDatapath
  import eulerRotPkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int ITER = 16,
  parameter int GB   = 4,
  parameter int ZG   = 4,
  parameter int KW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  rotCtl_t         ctl,
  input  logic [3*DW-1:0] uIn,
  input  logic [3*AW-1:0] angIn,
  output logic [3*DW-1:0] uOut
);

  localparam int IW = DW + 2 + GB;     // headroom for gain and norm, plus guard
  localparam int ZW = AW + ZG + 1;     // residual angle with extra fraction bits
  localparam int FR = AW - 3 + ZG;     // fraction bits of the residual angle

  function automatic int atanCode(input int i);
    real v;
    v = $atan(2.0 ** (-i)) * (2.0 ** FR);
    return $rtoi(v + 0.5);
  endfunction

  function automatic int kinvCode();
    real p;
    p = 1.0;
    for (int i = 0; i < ITER; i++) p = p / $sqrt(1.0 + 2.0 ** (-2 * i));
    return $rtoi(p * (2.0 ** (KW - 2)) + 0.5);
  endfunction

  localparam logic signed [ZW-1:0] PI_Z   = ZW'($rtoi(3.141592653589793 * (2.0 ** FR) + 0.5));
  localparam logic signed [ZW-1:0] HALF_Z = ZW'($rtoi(1.5707963267948966 * (2.0 ** FR) + 0.5));
  localparam logic signed [KW-1:0] KINV   = KW'(kinvCode());

  logic signed [ZW-1:0] atanTab [ITER];
  for (genvar g = 0; g < ITER; g++) begin : g_atan
    localparam logic signed [ZW-1:0] AT = ZW'(atanCode(g));
    assign atanTab[g] = AT;
  end

  logic signed [IW-1:0] vec     [3];
  logic signed [IW-1:0] vecNext [3];
  logic        [AW-1:0] ang     [3];
  logic signed [DW-1:0] outReg  [3];
  logic signed [IW-1:0] xr, yr, xNext, yNext, xSh, ySh, aSel, bSel, compX, compY;
  logic signed [ZW-1:0] zr, zNext, zIn;
  logic signed [IW+KW-1:0] prodX, prodY;
  logic [AW-1:0] angSel;
  logic [1:0] idxA, idxB;
  logic foldHi, foldLo, dirPos;

  assign idxA   = pairFirst(ctl.stage);
  assign idxB   = pairSecond(ctl.stage);
  assign aSel   = vec[idxA];
  assign bSel   = vec[idxB];
  assign angSel = ang[angleOf(ctl.stage)];
  assign zIn    = {angSel[AW-1], angSel, {ZG{1'b0}}};
  assign foldHi = zIn > HALF_Z;
  assign foldLo = zIn < -HALF_Z;

  // one CORDIC rotation-mode micro-step
  assign xSh    = xr >>> ctl.iterIdx;
  assign ySh    = yr >>> ctl.iterIdx;
  assign dirPos = !zr[ZW-1];
  assign xNext  = dirPos ? xr - ySh : xr + ySh;
  assign yNext  = dirPos ? yr + xSh : yr - xSh;
  assign zNext  = dirPos ? zr - atanTab[ctl.iterIdx[$clog2(ITER)-1:0]]
                         : zr + atanTab[ctl.iterIdx[$clog2(ITER)-1:0]];

  // gain removal
  assign prodX = xr * KINV;
  assign prodY = yr * KINV;
  assign compX = IW'(prodX >>> (KW - 2));
  assign compY = IW'(prodY >>> (KW - 2));

  always_comb begin
    for (int k = 0; k < 3; k++) vecNext[k] = vec[k];
    if (ctl.comp) begin
      vecNext[idxA] = compX;
      vecNext[idxB] = compY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      for (int k = 0; k < 3; k++) begin
        vec[k]    <= '0;
        ang[k]    <= '0;
        outReg[k] <= '0;
      end
      xr <= '0;
      yr <= '0;
      zr <= '0;
    end else begin
      if (ctl.load) begin
        for (int k = 0; k < 3; k++) begin
          vec[k] <= {{2{uIn[k*DW+DW-1]}}, uIn[k*DW +: DW], {GB{1'b0}}};
          ang[k] <= angIn[k*AW +: AW];
        end
      end else begin
        for (int k = 0; k < 3; k++) vec[k] <= vecNext[k];
      end
      if (ctl.fold) begin
        xr <= (foldHi || foldLo) ? -aSel : aSel;
        yr <= (foldHi || foldLo) ? -bSel : bSel;
        zr <= foldHi ? zIn - PI_Z : (foldLo ? zIn + PI_Z : zIn);
      end else if (ctl.iter) begin
        xr <= xNext;
        yr <= yNext;
        zr <= zNext;
      end
      if (ctl.finish) begin
        for (int k = 0; k < 3; k++) outReg[k] <= DW'(vecNext[k] >>> GB);
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_out
    assign uOut[g*DW +: DW] = outReg[g];
  end

  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fold |=> (zr <= HALF_Z && zr >= -HALF_Z)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.finish && !ctl.clear) |=> $stable(uOut)); // R9

endmodule

// File: rtl/eulerNedRotator.sv
module eulerNedRotator
  import eulerRotPkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int ITER = DW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            restart,
  input  logic            inValid,
  input  logic [3*DW-1:0] uIn,
  input  logic [3*AW-1:0] angIn,
  output logic            ready,
  output logic            outValid,
  output logic [3*DW-1:0] uOut
);

  rotCtl_t ctl;

  eulerRotCtl #(.ITER(ITER)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (restart),
    .inValid  (inValid),
    .ready    (ready),
    .outValid (outValid),
    .ctl      (ctl)
  );

  eulerRotDatapath #(.DW(DW), .AW(AW), .ITER(ITER)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .uIn   (uIn),
    .angIn (angIn),
    .uOut  (uOut)
  );

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !outValid); // R3

endmodule

// File: tb/tb_eulerNedRotator.sv
module tb_eulerNedRotator;

  localparam int DW  = 16;
  localparam int AW  = 16;
  localparam int LAT = 3 * (DW + 2);
  localparam int TOL = 6;
  localparam real ASCALE = 8192.0;

  logic clk = 1'b0;
  logic rstN, restart, inValid, ready, outValid;
  logic [3*DW-1:0] uIn, uOut;
  logic [3*AW-1:0] angIn;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  eulerNedRotator dut (
    .clk(clk), .rstN(rstN), .restart(restart), .inValid(inValid),
    .uIn(uIn), .angIn(angIn), .ready(ready), .outValid(outValid), .uOut(uOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int angCode(input real r);
    return $rtoi(r * ASCALE);
  endfunction

  function automatic int outAt(input int k);
    return int'($signed(uOut[k*DW +: DW]));
  endfunction

  task automatic drive(input int u0, u1, u2, a0, a1, a2);
    uIn   = {DW'(u2), DW'(u1), DW'(u0)};
    angIn = {AW'(a2), AW'(a1), AW'(a0)};
  endtask

  // one full transaction with all checks; pokeBusy offers a second input while busy
  task automatic runCase(input string req, input int u0, u1, u2,
                         input int a0, a1, a2, input bit pokeBusy);
    real n, e, d, c, s, t1, t2, ph, th, ps;
    real ex [3];
    int cnt;
    ph = a0 / ASCALE; th = a1 / ASCALE; ps = a2 / ASCALE;
    n = u0; e = u1; d = u2;
    c = $cos(ps); s = $sin(ps);
    t1 = n * c - e * s; t2 = n * s + e * c; n = t1; e = t2;
    c = $cos(th); s = $sin(th);
    t1 = d * c - n * s; t2 = d * s + n * c; d = t1; n = t2;
    c = $cos(ph); s = $sin(ph);
    t1 = e * c - d * s; t2 = e * s + d * c; e = t1; d = t2;
    ex[0] = n; ex[1] = e; ex[2] = d;

    while (!ready) @(negedge clk);
    drive(u0, u1, u2, a0, a1, a2);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(ready == 1'b0, "R2", {req, " ready after accept"}, int'(ready), 0);
    cnt = 0;
    while (!outValid && cnt < 4 * LAT) begin
      if (pokeBusy && cnt == 5) begin
        drive(-u0, 3000, -2000, 1000, -7000, 9000);
        inValid = 1'b1;
      end
      if (pokeBusy && cnt == 8) inValid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(cnt == LAT, "R4", {req, " latency"}, cnt, LAT);
    for (int k = 0; k < 3; k++) begin
      int exi;
      exi = $rtoi(ex[k] + (ex[k] >= 0.0 ? 0.5 : -0.5));
      chk(outAt(k) - exi <= TOL && exi - outAt(k) <= TOL, req,
          $sformatf("component %0d", k), outAt(k), exi);
    end
    @(negedge clk);
    chk(outValid == 1'b0, "R4", {req, " strobe width"}, int'(outValid), 0);
    chk(ready == 1'b1, "R2", {req, " ready return"}, int'(ready), 1);
  endtask

  task automatic testReset();
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    chk(uOut == '0, "R1", "uOut after reset", int'(uOut[DW-1:0]), 0);
  endtask

  task automatic testIdle();
    int seen;
    seen = 0;
    drive(1000, 2000, 3000, 100, 200, 300);
    inValid = 1'b0;
    for (int i = 0; i < 2 * LAT; i++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, "R3", "no result without inValid", seen, 0);
    chk(uOut == '0, "R3", "uOut untouched without inValid", outAt(0), 0);
  endtask

  task automatic testHold();
    logic [3*DW-1:0] held;
    held = uOut;
    drive(-5, 7, 9, 11, 13, 15);
    for (int i = 0; i < 30; i++) @(negedge clk);
    chk(uOut == held, "R9", "uOut held while idle", outAt(0), int'($signed(held[DW-1:0])));
  endtask

  task automatic testRestart();
    int seen;
    seen = 0;
    while (!ready) @(negedge clk);
    drive(3000, -2000, 1000, 4000, 5000, 6000);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    for (int i = 0; i < 10; i++) @(negedge clk);
    restart = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    inValid = 1'b0;
    chk(ready == 1'b1, "R8", "ready after restart", int'(ready), 1);
    chk(uOut == '0, "R8", "uOut cleared by restart", outAt(0), 0);
    for (int i = 0; i < 2 * LAT; i++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, "R8", "aborted input gives no result", seen, 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; restart = 1'b0; inValid = 1'b0;
    uIn = '0; angIn = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    runCase("R7", 4000, -3000, 2000, 0, 0, 0, 1'b0);
    runCase("R5", 4000, 1000, -500, 0, 0, angCode(0.5), 1'b0);
    runCase("R5", 3000, -1500, 2500, 0, angCode(-0.8), 0, 1'b0);
    runCase("R5", -2000, 3500, 1200, angCode(1.2), 0, 0, 1'b0);
    runCase("R5", 2500, 2500, -3000, angCode(0.3), angCode(-1.1), angCode(1.4), 1'b0);
    runCase("R6", 3500, -1000, 2000, angCode(3.0), angCode(-2.5), angCode(2.2), 1'b0);
    runCase("R6", -1500, 4000, -2500, 25736, -25736, angCode(-1.9), 1'b0);
    runCase("R3", 1000, 2000, 3000, angCode(0.7), angCode(0.4), angCode(-0.6), 1'b1);
    testHold();
    testRestart();
    runCase("R8", 2000, -2000, 1500, angCode(-0.4), angCode(1.5), angCode(2.8), 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule